// File: doc/BRIEF.md
# Debug Access Cycle-Stealing Arbiter

This block places memory reads and writes issued by a background debug command interface onto a CPU memory bus without disturbing the running program. A pending debug access waits for a bus cycle the CPU leaves unused and takes it. If no such cycle turns up within a fixed search window, the arbiter freezes the CPU and takes the bus by force. An access that needs two bus cycles, a 16-bit transfer at an odd byte address, keeps the CPU frozen across both cycles even when the first cycle was free.

While active debug mode is set, a small window of byte-wide debug registers sits at a fixed address range. Debug accesses to that window are served internally with no bus cycle. CPU reads of the window are masked so that they never see register contents. A request to enter active debug mode passes through only when debug is enabled. Otherwise it is dropped and causes no delay or freeze.

Top module: `dbg_steal_arb`

## Requirements
- R1: `mem_req` is high only in cycles where `cpu_idle` or `cpu_freeze` is high, so a debug bus cycle never collides with a CPU cycle.
- R2: A single-cycle access drives its bus cycle in the first waiting cycle that has `cpu_idle` high, provided this is within TIMEOUT (default 128) waiting cycles. When that holds, `cpu_freeze` stays low for the whole access.
- R3: After TIMEOUT consecutive waiting cycles without `cpu_idle`, `cpu_freeze` rises and the bus cycle is taken in the following cycle, whatever `cpu_idle` does then.
- R4: Byte lanes follow the address:
  - A byte access at an even address uses `mem_be`=01; at an odd address it uses `mem_be`=10.
  - A byte read returns the byte zero-extended.
  - An aligned 16-bit access is one cycle with `mem_be`=11.
  - A 16-bit access at an odd address takes two cycles. The first goes to the address and carries the low data byte. The second goes to the address plus one and carries the high data byte.
  - `cpu_freeze` is high in both cycles of a two-cycle access, even when the first one was idle.
- R5: `dbg_done` is high for exactly one cycle, the cycle after the last bus or register cycle. In that cycle `dbg_rdata` holds the read result and `cpu_freeze` is low.
- R6: `cmd_ready` goes low on the cycle after a request is accepted and stays low until the `dbg_done` cycle, so only one request is outstanding.
- R7: Memory commands outside the register window are carried out the same way whether `act_mode` is high or low.
- R8: `bkgd_go` is high in the cycle after `bkgd_req` is sampled high, and only if `dbg_en` was high at that time. A request made while `dbg_en` is low produces neither `bkgd_go` nor `cpu_freeze`.
- R9: With `act_mode` high, a debug access to REG_BASE .. REG_BASE+NREG-1 (default 0xFF00..0xFF07) is served by the register file:
  - It drives no bus cycle and causes no freeze.
  - It completes with `dbg_done` two cycles after acceptance.
  - A 16-bit access at index i covers i (low byte) and i+1 modulo NREG (high byte).
- R10: `cpu_rdata` is zero whenever `act_mode` is high and `cpu_addr` falls in the register window; otherwise it equals `mem_rdata`.
- R11: With `act_mode` low, a debug access to the register window addresses goes to the memory bus like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug enable |
| act_mode | input | 1 | Active debug mode flag |
| bkgd_req | input | 1 | Request to enter active debug mode |
| bkgd_go | output | 1 | Forwarded mode-entry request (gated by enable) |
| cmd_valid | input | 1 | Debug command request |
| cmd_ready | output | 1 | Arbiter can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wide | input | 1 | 1 = 16-bit, 0 = byte |
| cmd_addr | input | AW | Byte address |
| cmd_wdata | input | DW | Write data (byte in low lane) |
| dbg_rdata | output | DW | Read result, valid with dbg_done |
| dbg_done | output | 1 | One-cycle completion pulse |
| cpu_idle | input | 1 | CPU leaves the bus unused this cycle |
| cpu_freeze | output | 1 | CPU freeze request |
| cpu_addr | input | AW | CPU read address for window masking |
| cpu_rdata | output | DW | Read data returned to the CPU |
| mem_req | output | 1 | Debug owns the bus this cycle |
| mem_we | output | 1 | Debug write strobe |
| mem_be | output | 2 | Byte lane enables |
| mem_addr | output | AW | Debug bus address |
| mem_wdata | output | DW | Debug bus write data |
| mem_rdata | input | DW | Bus read data (same cycle) |

## Verification
The checker watches the following on every cycle:
- no debug bus cycle lands on a busy, unfrozen CPU;
- no wait lasts past the timeout;
- freeze never spans more than two cycles and is down when done fires;
- done is a single-cycle pulse;
- ready drops after acceptance;
- the mode-entry request only passes when enable was set.

Only the bench's scenarios can show the rest:
- exact cycle counts for each idle pattern, including idle arriving on the last waiting cycle versus one cycle too late;
- lane steering and data for every size at every low address;
- register-window wraparound;
- window masking of CPU reads.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_FORCE,
      ST_TAIL,
      ST_REG
   } arb_st_e;

   function automatic logic [15:0] dup_byte(input logic [7:0] b);
      return {b, b};
   endfunction

endpackage

// File: rtl/dbg_win_decode.sv
module dbg_win_decode #(
   parameter int               AW       = 16,
   parameter int               NREG     = 8,
   parameter logic [AW-1:0]    REG_BASE = 'hFF00
) (
   input  logic [AW-1:0] addr,
   input  logic          act_mode,
   output logic          reg_hit
);
   localparam int  BASE_I  = int'(REG_BASE);
   localparam bit  POW2    = (NREG & (NREG - 1)) == 0;
   localparam bit  ALIGNED = POW2 && ((BASE_I % NREG) == 0);

   if (NREG < 2) begin : g_bad_nreg
      $error("dbg_win_decode: NREG must be at least 2");
   end

   generate
      if (ALIGNED) begin : g_mask
         localparam logic [AW-1:0] MASK = ~(AW'(NREG) - AW'(1));
         assign reg_hit = act_mode && ((addr & MASK) == REG_BASE);
      end else begin : g_range
         logic [AW:0] off;
         assign off     = {1'b0, addr} - {1'b0, REG_BASE};
         assign reg_hit = act_mode && !off[AW] && (off < (AW+1)'(NREG));
      end
   endgenerate

endmodule

// File: rtl/dbg_timeout_ctr.sv
module dbg_timeout_ctr #(
   parameter int LIMIT = 128,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic expire
);
   logic [CW-1:0] cnt_q;

   if (LIMIT < 2) begin : g_bad_limit
      $error("dbg_timeout_ctr: LIMIT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // the step that brings the count to LIMIT ends the search
   assign expire = step && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file #(
   parameter int NREG = 8,
   parameter int BW   = 8,
   parameter int IW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wide,
   input  logic [IW-1:0] idx,
   input  logic [2*BW-1:0] wdata,
   output logic [2*BW-1:0] rdata
);
   logic [NREG*BW-1:0] flat;
   logic [IW-1:0]      idx_hi;

   if ((NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("dbg_reg_file: NREG must be a power of two");
   end

   assign idx_hi = idx + IW'(1);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         logic [BW-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= '0;
            end else if (wr_en) begin
               if (idx == IW'(i)) begin
                  r_q <= wdata[BW-1:0];
               end else if (wide && (idx_hi == IW'(i))) begin
                  r_q <= wdata[2*BW-1:BW];
               end
            end
         end
         assign flat[i*BW +: BW] = r_q;
      end
   endgenerate

   always_comb begin
      rdata[BW-1:0]    = flat[idx*BW +: BW];
      rdata[2*BW-1:BW] = wide ? flat[idx_hi*BW +: BW] : '0;
   end

endmodule

// File: rtl/dbg_lane_mux.sv
module dbg_lane_mux #(
   parameter int BW = 8
) (
   input  logic            bus_odd,
   input  logic            whole,
   input  logic            phase,
   input  logic [2*BW-1:0] wdata,
   input  logic [2*BW-1:0] rdata,
   output logic [1:0]      be,
   output logic [2*BW-1:0] bus_wdata,
   output logic [BW-1:0]   rd_byte
);
   logic [BW-1:0] wr_byte;

   assign wr_byte = phase ? wdata[2*BW-1:BW] : wdata[BW-1:0];

   always_comb begin
      if (whole) begin
         be        = 2'b11;
         bus_wdata = wdata;
      end else begin
         be        = bus_odd ? 2'b10 : 2'b01;
         bus_wdata = {wr_byte, wr_byte};
      end
   end

   assign rd_byte = bus_odd ? rdata[2*BW-1:BW] : rdata[BW-1:0];

endmodule

// File: rtl/dbg_steal_arb.sv
module dbg_steal_arb
   import dbg_arb_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 16,
   parameter int            TIMEOUT  = 128,
   parameter int            NREG     = 8,
   parameter logic [AW-1:0] REG_BASE = 'hFF00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dbg_en,
   input  logic          act_mode,
   input  logic          bkgd_req,
   output logic          bkgd_go,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic          cmd_write,
   input  logic          cmd_wide,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   output logic [DW-1:0] dbg_rdata,
   output logic          dbg_done,
   input  logic          cpu_idle,
   output logic          cpu_freeze,
   input  logic [AW-1:0] cpu_addr,
   output logic [DW-1:0] cpu_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [1:0]    mem_be,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int BW = DW / 2;
   localparam int IW = $clog2(NREG);

   if (DW != 2 * BW || BW < 1) begin : g_bad_dw
      $error("dbg_steal_arb: DW must be two byte lanes");
   end
   if (AW <= IW) begin : g_bad_aw
      $error("dbg_steal_arb: AW too small for the register window");
   end

   arb_st_e       st_q, st_d;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q, rd_q;
   logic          wr_q, wide_q;
   logic          done_q, frz_q, go_q;

   logic          split, whole, in_wait, bus_go, phase, fin;
   logic          frz_set, expire;
   logic          c_reg_hit, u_reg_hit;
   logic [AW-1:0] bus_a;
   logic [1:0]    be;
   logic [DW-1:0] bus_wd, reg_rd;
   logic [BW-1:0] rd_byte;

   // ---- address window decode: one for debug commands, one for CPU reads
   dbg_win_decode #(.AW(AW), .NREG(NREG), .REG_BASE(REG_BASE)) u_cmd_dec (
      .addr     (cmd_addr),
      .act_mode (act_mode),
      .reg_hit  (c_reg_hit)
   );

   dbg_win_decode #(.AW(AW), .NREG(NREG), .REG_BASE(REG_BASE)) u_cpu_dec (
      .addr     (cpu_addr),
      .act_mode (act_mode),
      .reg_hit  (u_reg_hit)
   );

   // ---- idle-search timeout
   dbg_timeout_ctr #(.LIMIT(TIMEOUT)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (st_q == ST_IDLE),
      .step   (in_wait && !cpu_idle),
      .expire (expire)
   );

   // ---- debug register window
   dbg_reg_file #(.NREG(NREG), .BW(BW), .IW(IW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (st_q == ST_REG && wr_q),
      .wide  (wide_q),
      .idx   (a_q[IW-1:0]),
      .wdata (d_q),
      .rdata (reg_rd)
   );

   // ---- byte lane steering
   dbg_lane_mux #(.BW(BW)) u_lanes (
      .bus_odd   (bus_a[0]),
      .whole     (whole),
      .phase     (phase),
      .wdata     (d_q),
      .rdata     (mem_rdata),
      .be        (be),
      .bus_wdata (bus_wd),
      .rd_byte   (rd_byte)
   );

   assign split   = wide_q && a_q[0];
   assign whole   = wide_q && !a_q[0];
   assign in_wait = (st_q == ST_WAIT);
   assign phase   = (st_q == ST_TAIL);
   assign bus_go  = (in_wait && cpu_idle) || (st_q == ST_FORCE) || phase;
   assign bus_a   = phase ? a_q + AW'(1) : a_q;

   // freeze is raised for a split access landing on an idle cycle, or at timeout
   assign frz_set = in_wait && ((cpu_idle && split) || (!cpu_idle && expire));

   always_comb begin
      st_d = st_q;
      fin  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (cmd_valid) begin
               st_d = c_reg_hit ? ST_REG : ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (cpu_idle) begin
               if (split) begin
                  st_d = ST_TAIL;
               end else begin
                  st_d = ST_IDLE;
                  fin  = 1'b1;
               end
            end else if (expire) begin
               st_d = ST_FORCE;
            end
         end
         ST_FORCE: begin
            if (split) begin
               st_d = ST_TAIL;
            end else begin
               st_d = ST_IDLE;
               fin  = 1'b1;
            end
         end
         ST_TAIL: begin
            st_d = ST_IDLE;
            fin  = 1'b1;
         end
         ST_REG: begin
            st_d = ST_IDLE;
            fin  = 1'b1;
         end
         default: begin
            st_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         d_q    <= '0;
         wr_q   <= 1'b0;
         wide_q <= 1'b0;
         done_q <= 1'b0;
         frz_q  <= 1'b0;
         go_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= fin;
         go_q   <= bkgd_req && dbg_en;
         if (st_q == ST_IDLE && cmd_valid) begin
            a_q    <= cmd_addr;
            d_q    <= cmd_wdata;
            wr_q   <= cmd_write;
            wide_q <= cmd_wide;
         end
         if (fin) begin
            frz_q <= 1'b0;
         end else if (frz_set) begin
            frz_q <= 1'b1;
         end
      end
   end

   // read result assembly
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (!wr_q) begin
         if (st_q == ST_REG) begin
            rd_q <= reg_rd;
         end else if (bus_go) begin
            if (phase) begin
               rd_q[DW-1:BW] <= rd_byte;
            end else if (whole) begin
               rd_q <= mem_rdata;
            end else begin
               rd_q <= {{BW{1'b0}}, rd_byte};
            end
         end
      end
   end

   assign cmd_ready  = (st_q == ST_IDLE);
   assign dbg_done   = done_q;
   assign dbg_rdata  = rd_q;
   assign bkgd_go    = go_q;
   assign cpu_freeze = frz_q || (in_wait && cpu_idle && split);
   assign mem_req    = bus_go;
   assign mem_we     = bus_go && wr_q;
   assign mem_be     = bus_go ? be : 2'b00;
   assign mem_addr   = bus_a;
   assign mem_wdata  = bus_wd;
   assign cpu_rdata  = u_reg_hit ? '0 : mem_rdata;

endmodule

// File: rtl/dbg_steal_arb_chk.sv
module dbg_steal_arb_chk #(
   parameter int TIMEOUT = 128,
   parameter int RW      = $clog2(TIMEOUT + 2)
) (
   input logic clk,
   input logic rst_n,
   input logic dbg_en,
   input logic bkgd_go,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic dbg_done,
   input logic cpu_idle,
   input logic cpu_freeze,
   input logic mem_req
);
   logic [RW-1:0] wait_run;
   logic [1:0]    frz_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_run <= '0;
         frz_run  <= '0;
      end else begin
         if (!cmd_ready && !mem_req) begin
            if (wait_run != '1) wait_run <= wait_run + RW'(1);
         end else begin
            wait_run <= '0;
         end
         if (cpu_freeze) begin
            if (frz_run != 2'b11) frz_run <= frz_run + 2'd1;
         end else begin
            frz_run <= '0;
         end
      end
   end

   AST_NO_INTRUDE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (cpu_idle || cpu_freeze)); // R1

   AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !mem_req) |-> (wait_run < RW'(TIMEOUT))); // R3

   AST_FREEZE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_freeze |-> (frz_run < 2'd2)); // R4

   AST_DONE_UNFROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_done |-> !cpu_freeze); // R5

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_done |=> !dbg_done); // R5

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready); // R6

   AST_BKGD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      bkgd_go |-> $past(dbg_en)); // R8

endmodule

bind dbg_steal_arb dbg_steal_arb_chk #(.TIMEOUT(TIMEOUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_en     (dbg_en),
   .bkgd_go    (bkgd_go),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .dbg_done   (dbg_done),
   .cpu_idle   (cpu_idle),
   .cpu_freeze (cpu_freeze),
   .mem_req    (mem_req)
);

// File: tb/test_dbg_steal_arb.sv
`timescale 1ns/1ps
module test_dbg_steal_arb;
   localparam int TO = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_en = 1'b0, act_mode = 1'b0, bkgd_req = 1'b0, bkgd_go;
   logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cmd_wide = 1'b0;
   logic [15:0] cmd_addr = '0, cmd_wdata = '0, dbg_rdata;
   logic        dbg_done, cpu_idle = 1'b0, cpu_freeze;
   logic [15:0] cpu_addr = '0, cpu_rdata;
   logic        mem_req, mem_we;
   logic [1:0]  mem_be;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;

   logic [7:0]  bm [256];
   logic [7:0]  sh [256];
   logic [7:0]  ba;
   int          n_run = 0, n_fail = 0, n_intr = 0;

   always #2 clk = ~clk;

   dbg_steal_arb i_dbg_steal_arb (
      .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .act_mode(act_mode),
      .bkgd_req(bkgd_req), .bkgd_go(bkgd_go),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_wide(cmd_wide), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .dbg_rdata(dbg_rdata), .dbg_done(dbg_done),
      .cpu_idle(cpu_idle), .cpu_freeze(cpu_freeze),
      .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // bus memory model, 256 bytes aliased over the address space
   assign ba        = mem_req ? mem_addr[7:0] : cpu_addr[7:0];
   assign mem_rdata = {bm[{ba[7:1], 1'b1}], bm[{ba[7:1], 1'b0}]};

   always @(posedge clk) begin
      if (mem_req && !cpu_idle && !cpu_freeze) n_intr++;
      if (mem_req && mem_we) begin
         if (mem_be[0]) bm[{mem_addr[7:1], 1'b0}] <= mem_wdata[7:0];
         if (mem_be[1]) bm[{mem_addr[7:1], 1'b1}] <= mem_wdata[15:8];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_cmd(input bit wr, input bit wd, input logic [15:0] a,
                          input logic [15:0] d, input int idle_at,
                          output logic [15:0] rd, output int nwait,
                          output int nfrz, output int nbus, output int nrdy);
      int k;
      nwait = 0; nfrz = 0; nbus = 0; nrdy = 0; rd = '0; k = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_wide = wd;
      cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (k < 1000) begin
         cpu_idle = (idle_at >= 0) && (k >= idle_at);
         #1;
         if (dbg_done) begin
            rd = dbg_rdata;
            break;
         end
         if (mem_req) nbus++;
         if (cpu_freeze) nfrz++;
         if (cmd_ready) nrdy++;
         if (!cmd_ready && !mem_req) nwait++;
         @(negedge clk);
         k++;
      end
      if (k >= 1000) chk(1'b0, "R5", "done never seen", k, 0);
      cpu_idle = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] rd, d, ex;
      int nw, nf, nb, nr, ia, ew, ef, eb;
      bit multi, forced;
      int idle_pat [5] = '{0, 3, 127, 128, -1};

      for (int i = 0; i < 256; i++) begin
         bm[i] = 8'(i * 3 + 1);
         sh[i] = 8'(i * 3 + 1);
      end
      repeat (3) @(negedge clk);
      #1;
      chk(cmd_ready == 1'b1, "R6", "reset ready", cmd_ready, 1);
      chk(cpu_freeze == 1'b0, "R1", "reset freeze", cpu_freeze, 0);
      chk(dbg_done == 1'b0, "R5", "reset done", dbg_done, 0);
      chk(mem_req == 1'b0, "R1", "reset mem_req", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: low addresses, both sizes, idle arrival patterns, both modes (R2 R3 R4 R7)
      for (int a = 0; a < 16; a++) begin
         for (int wd = 0; wd < 2; wd++) begin
            for (int ip = 0; ip < 5; ip++) begin
               ia       = idle_pat[ip];
               act_mode = ip[0];
               multi    = (wd == 1) && (a % 2 == 1);
               forced   = !(ia >= 0 && ia < TO);
               ew = forced ? TO : ia;
               eb = multi ? 2 : 1;
               ef = multi ? 2 : (forced ? 1 : 0);
               d  = 16'(a * 613 + wd * 97 + ip * 29 + 16'h5A3C);
               run_cmd(1'b1, wd[0], 16'(a), d, ia, rd, nw, nf, nb, nr);
               sh[a] = d[7:0];
               if (wd == 1) sh[a + 1] = d[15:8];
               chk(nw == ew, forced ? "R3" : "R2", "write wait cycles", nw, ew);
               chk(nf == ef, multi ? "R4" : "R2", "write freeze cycles", nf, ef);
               chk(nb == eb, "R4", "write bus cycles", nb, eb);
               chk(nr == 0, "R6", "ready while busy", nr, 0);
               run_cmd(1'b0, wd[0], 16'(a), 16'h0, ia, rd, nw, nf, nb, nr);
               ex = (wd == 1) ? {sh[a + 1], sh[a]} : {8'h00, sh[a]};
               chk(rd == ex, "R7", "read data", rd, ex);
               chk(nf == ef, multi ? "R4" : "R3", "read freeze cycles", nf, ef);
               chk(nw == ew, "R2", "read wait cycles", nw, ew);
            end
         end
      end
      chk(n_intr == 0, "R1", "bus cycles on busy unfrozen CPU", n_intr, 0);

      // register window (R9)
      act_mode = 1'b1;
      for (int i = 0; i < 8; i++) begin
         run_cmd(1'b1, 1'b0, 16'hFF00 + 16'(i), 16'(8'h11 * (i + 1)), -1, rd, nw, nf, nb, nr);
         chk(nb == 0 && nf == 0 && nw == 1, "R9", "reg write cost", nb + nf, 0);
      end
      for (int i = 0; i < 8; i++) begin
         run_cmd(1'b0, 1'b0, 16'hFF00 + 16'(i), 16'h0, -1, rd, nw, nf, nb, nr);
         chk(rd == 16'(8'h11 * (i + 1)), "R9", "reg byte read", rd, 8'h11 * (i + 1));
      end
      run_cmd(1'b0, 1'b1, 16'hFF07, 16'h0, -1, rd, nw, nf, nb, nr);
      chk(rd == 16'h1188, "R9", "reg wide wrap read", rd, 16'h1188);
      run_cmd(1'b1, 1'b1, 16'hFF03, 16'hBEEF, -1, rd, nw, nf, nb, nr);
      chk(nb == 0 && nf == 0, "R9", "odd wide reg write no bus", nb + nf, 0);
      run_cmd(1'b0, 1'b1, 16'hFF03, 16'h0, -1, rd, nw, nf, nb, nr);
      chk(rd == 16'hBEEF, "R9", "odd wide reg read", rd, 16'hBEEF);
      run_cmd(1'b0, 1'b0, 16'hFF05, 16'h0, -1, rd, nw, nf, nb, nr);
      chk(rd == 16'h0066, "R9", "neighbour untouched", rd, 16'h0066);

      // CPU read masking (R10)
      @(negedge clk);
      cpu_addr = 16'hFF02; #1;
      chk(cpu_rdata == 16'h0, "R10", "cpu read in window", cpu_rdata, 0);
      cpu_addr = 16'hFF08; #1;
      chk(cpu_rdata == {sh[9], sh[8]}, "R10", "cpu read past window", cpu_rdata, {sh[9], sh[8]});
      cpu_addr = 16'hFEFE; #1;
      chk(cpu_rdata == {sh[255], sh[254]}, "R10", "cpu read below window", cpu_rdata, {sh[255], sh[254]});
      act_mode = 1'b0; cpu_addr = 16'hFF02; #1;
      chk(cpu_rdata == {sh[3], sh[2]}, "R10", "cpu read mode off", cpu_rdata, {sh[3], sh[2]});

      // window address with mode off goes to the bus (R11)
      run_cmd(1'b0, 1'b0, 16'hFF03, 16'h0, 0, rd, nw, nf, nb, nr);
      chk(nb == 1, "R11", "bus cycle for window addr", nb, 1);
      chk(rd == {8'h00, sh[3]}, "R11", "bus data for window addr", rd, sh[3]);

      // mode-entry gating (R8)
      nf = 0; nb = 0;
      @(negedge clk); dbg_en = 1'b0; bkgd_req = 1'b1;
      @(negedge clk); bkgd_req = 1'b0;
      for (int i = 0; i < 3; i++) begin
         #1;
         if (bkgd_go) nb++;
         if (cpu_freeze) nf++;
         @(negedge clk);
      end
      chk(nb == 0, "R8", "go while disabled", nb, 0);
      chk(nf == 0, "R8", "freeze while disabled", nf, 0);
      dbg_en = 1'b1; bkgd_req = 1'b1;
      @(negedge clk); bkgd_req = 1'b0; #1;
      chk(bkgd_go == 1'b1, "R8", "go when enabled", bkgd_go, 1);
      @(negedge clk); #1;
      chk(bkgd_go == 1'b0, "R8", "go is one cycle", bkgd_go, 0);

      chk(n_intr == 0, "R1", "final intrusion count", n_intr, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule